// File: doc/BRIEF.md
# Clock Count Error PI Tuner

This block closes a software-style frequency loop in hardware. A free-running 16-bit counter, clocked by the local master clock, is sampled once per fixed measurement interval. The sample arrives here together with an update strobe. The block predicts where the counter should have landed, which is the previous sample plus a nominal increment chosen by the clock family. It turns the miss into a signed error and runs that error through a proportional-integral controller. The result is a 20-bit tuning word for a downstream fractional modulator.

Two clock families are supported: one around 22.5792 MHz and one around 24.576 MHz. Each family has its own nominal increment and its own centre tuning word. An init request selects the family and restarts the loop from a clean state. A new word is issued only when the controller result moves, so the consumer sees an update only when there is something to apply.

Top module: `clk_err_pi_tuner`

## Requirements
- R1: After reset, `tune_o` is 0 and `tune_valid_o` is 0. The 22.5792 MHz family (`fam_sel_i` = 0) is active, and the next strobe is treated as a first sample.
- R2: The first strobe after reset or after an init only stores its timestamp and never raises `tune_valid_o`.
- R3: The predicted timestamp is the stored timestamp plus the family increment, modulo 2^16. The increment is 29184 for family 0 and 49152 for family 1. The difference (sample minus prediction) is read as a signed 16-bit value, so counter wrap-around is handled.
- R4: The loop error is the negated difference, so a counter that runs ahead gives a negative error. A signed 32-bit integrator adds each error and saturates at its limits rather than wrapping.
- R5: The controller result is 32 times the updated integrator; the proportional gain is zero. The issued word is the family base plus this result. The base is 0x6CF42 for family 0 and 0x81062 for family 1.
- R6: A word is issued only when the controller result differs from the result of the previous counted update. That stored result is cleared to 0 by reset and by init.
- R7: The issued word is clamped to the range 0 to 0xFFFFF.
- R8: `tune_valid_o` is a one-cycle pulse in the cycle after the causing strobe, and `tune_o` holds its value whenever no pulse is present.
- R9: `init_i` loads the family from `fam_sel_i`, clears the integrator and the stored result, and re-arms the first-sample skip. A strobe in the same cycle as `init_i` is ignored, and its timestamp is not stored.
- R10: Every accepted strobe stores its timestamp as the base for the next prediction, including strobes that issue no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Restart the loop with the family on `fam_sel_i` |
| fam_sel_i | input | 1 | Family select: 0 = 22.5792 MHz, 1 = 24.576 MHz |
| strobe_i | input | 1 | One-cycle update strobe, once per measurement interval |
| stamp_i | input | 16 | Counter timestamp taken at the interval boundary |
| tune_o | output | 20 | Tuning word for the modulator |
| tune_valid_o | output | 1 | One-cycle pulse marking a new `tune_o` |

## Verification
The assertions assume that `strobe_i` and `init_i` are synchronous to `clk_i`, and that both are held low while reset is active. They also assume `stamp_i` is only meaningful in a strobe cycle. The stimulus drives every input on the falling edge and lowers each strobe after one cycle. Every random timestamp is formed as the prediction plus a bounded offset, so the signed 16-bit difference never aliases. The stimulus also places init and strobe together only in the directed case that R9 describes.

// File: rtl/pi_tuner_pkg.sv
package pi_tuner_pkg;

    localparam int STAMP_W_DEF = 16;
    localparam int TUNE_W_DEF  = 20;
    localparam int ACC_W_DEF   = 32;

    // nominal counter advance per interval and centre word, per family
    localparam logic [15:0] INC_FAM0  = 16'd29184;
    localparam logic [15:0] INC_FAM1  = 16'd49152;
    localparam logic [19:0] BASE_FAM0 = 20'h6CF42;
    localparam logic [19:0] BASE_FAM1 = 20'h81062;

    typedef struct packed {
        logic [15:0] inc;
        logic [19:0] base;
    } fam_cfg_t;

    function automatic fam_cfg_t fam_cfg(input logic sel);
        fam_cfg_t c;
        c.inc  = sel ? INC_FAM1  : INC_FAM0;
        c.base = sel ? BASE_FAM1 : BASE_FAM0;
        return c;
    endfunction

endpackage

// File: rtl/pi_phase_err.sv
module pi_phase_err #(
    parameter int STAMP_W = 16
) (
    input  logic [STAMP_W-1:0]        stamp_i,
    input  logic [STAMP_W-1:0]        prev_i,
    input  logic [STAMP_W-1:0]        inc_i,
    output logic signed [STAMP_W:0]   err_o
);
    logic [STAMP_W-1:0] pred;
    logic [STAMP_W-1:0] miss;

    always_comb begin
        pred  = prev_i + inc_i;
        miss  = stamp_i - pred;
        // counter ahead of prediction -> clock fast -> negative error
        err_o = -$signed({miss[STAMP_W-1], miss});
    end
endmodule

// File: rtl/pi_sat_acc.sv
module pi_sat_acc #(
    parameter int ACC_W = 32,
    parameter int IN_W  = 17
) (
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic signed [IN_W-1:0]  add_i,
    output logic signed [ACC_W-1:0] sum_o
);
    localparam logic [ACC_W-1:0] MAX_V = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_V = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0] wide;

    always_comb begin
        wide = {acc_i[ACC_W-1], acc_i} + {{(ACC_W+1-IN_W){add_i[IN_W-1]}}, add_i};
        if (wide[ACC_W] != wide[ACC_W-1]) begin
            sum_o = wide[ACC_W] ? MIN_V : MAX_V;
        end else begin
            sum_o = wide[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/pi_clamp.sv
module pi_clamp #(
    parameter int IN_W  = 40,
    parameter int OUT_W = 20
) (
    input  logic signed [IN_W-1:0] val_i,
    output logic [OUT_W-1:0]       word_o
);
    localparam logic [IN_W-1:0] TOP_V = {{(IN_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};

    always_comb begin
        if (val_i[IN_W-1]) begin
            word_o = '0;
        end else if (val_i > $signed(TOP_V)) begin
            word_o = {OUT_W{1'b1}};
        end else begin
            word_o = val_i[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/clk_err_pi_tuner.sv
module clk_err_pi_tuner
    import pi_tuner_pkg::*;
#(
    parameter int STAMP_W  = STAMP_W_DEF,
    parameter int TUNE_W   = TUNE_W_DEF,
    parameter int ACC_W    = ACC_W_DEF,
    parameter int KI_SHIFT = 5,
    parameter bit KP_EN    = 1'b0,
    parameter int KP_SHIFT = 0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               init_i,
    input  logic               fam_sel_i,
    input  logic               strobe_i,
    input  logic [STAMP_W-1:0] stamp_i,
    output logic [TUNE_W-1:0]  tune_o,
    output logic               tune_valid_o
);
    localparam int ERR_W = STAMP_W + 1;
    localparam int RES_W = ACC_W + KI_SHIFT + 2;
    localparam int SUM_W = RES_W + 1;

    typedef struct packed {
        logic                     skip;
        logic                     fam;
        logic [STAMP_W-1:0]       prev;
        logic signed [ACC_W-1:0]  integ;
        logic signed [RES_W-1:0]  last_res;
        logic [TUNE_W-1:0]        tune;
        logic                     vld;
    } st_t;

    localparam st_t ST_RST = '{skip: 1'b1, default: '0};

    st_t st_d, st_q;

    fam_cfg_t                cfg;
    logic [STAMP_W-1:0]      inc;
    logic signed [ERR_W-1:0] err;
    logic signed [ACC_W-1:0] integ_sum;
    logic signed [RES_W-1:0] i_term;
    logic signed [RES_W-1:0] p_term;
    logic signed [RES_W-1:0] res;
    logic signed [SUM_W-1:0] word_raw;
    logic [TUNE_W-1:0]       word_clamped;

    always_comb begin
        cfg = fam_cfg(st_q.fam);
        inc = STAMP_W'(cfg.inc);
    end

    pi_phase_err #(.STAMP_W(STAMP_W)) err_i (
        .stamp_i (stamp_i),
        .prev_i  (st_q.prev),
        .inc_i   (inc),
        .err_o   (err)
    );

    pi_sat_acc #(.ACC_W(ACC_W), .IN_W(ERR_W)) acc_i (
        .acc_i (st_q.integ),
        .add_i (err),
        .sum_o (integ_sum)
    );

    generate
        if (KP_EN) begin : g_prop
            assign p_term = $signed({{(RES_W-ERR_W){err[ERR_W-1]}}, err}) <<< KP_SHIFT;
        end else begin : g_noprop
            assign p_term = '0;
        end
    endgenerate

    always_comb begin
        i_term   = $signed({{(RES_W-ACC_W){integ_sum[ACC_W-1]}}, integ_sum}) <<< KI_SHIFT;
        res      = p_term + i_term;
        word_raw = $signed({res[RES_W-1], res})
                 + $signed({{(SUM_W-TUNE_W){1'b0}}, TUNE_W'(cfg.base)});
    end

    pi_clamp #(.IN_W(SUM_W), .OUT_W(TUNE_W)) clamp_i (
        .val_i  (word_raw),
        .word_o (word_clamped)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (init_i) begin
            st_d.fam      = fam_sel_i;
            st_d.skip     = 1'b1;
            st_d.integ    = '0;
            st_d.last_res = '0;
        end else if (strobe_i) begin
            st_d.prev = stamp_i;
            if (st_q.skip) begin
                st_d.skip = 1'b0;
            end else begin
                st_d.integ    = integ_sum;
                st_d.last_res = res;
                if (res != st_q.last_res) begin
                    st_d.tune = word_clamped;
                    st_d.vld  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign tune_o       = st_q.tune;
    assign tune_valid_o = st_q.vld;

endmodule

// File: rtl/clk_err_pi_tuner_chk.sv
module clk_err_pi_tuner_chk #(
    parameter int TUNE_W = 20
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              init_i,
    input logic              strobe_i,
    input logic [TUNE_W-1:0] tune_o,
    input logic              tune_valid_o
);
    logic armed;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed <= 1'b1;
        end else if (init_i) begin
            armed <= 1'b1;
        end else if (strobe_i) begin
            armed <= 1'b0;
        end
    end

    // R2
    first_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && !init_i && armed) |=> !tune_valid_o);

    // R8
    valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tune_valid_o |-> $past(strobe_i && !init_i));

    // R8
    word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tune_valid_o |-> $stable(tune_o));

    // R9
    init_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_i |=> !tune_valid_o);

endmodule

bind clk_err_pi_tuner clk_err_pi_tuner_chk #(.TUNE_W(TUNE_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_i       (init_i),
    .strobe_i     (strobe_i),
    .tune_o       (tune_o),
    .tune_valid_o (tune_valid_o)
);

// File: tb/clk_err_pi_tuner_tb_top.sv
module clk_err_pi_tuner_tb_top;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        init_i = 1'b0;
    logic        fam_sel_i = 1'b0;
    logic        strobe_i = 1'b0;
    logic [15:0] stamp_i = '0;
    logic [19:0] tune_o;
    logic        tune_valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    bit          m_skip;
    bit          m_fam;
    logic [15:0] m_prev;
    longint      m_integ;
    longint      m_last;
    logic [19:0] m_tune;

    always #5 clk = ~clk;

    clk_err_pi_tuner dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .init_i       (init_i),
        .fam_sel_i    (fam_sel_i),
        .strobe_i     (strobe_i),
        .stamp_i      (stamp_i),
        .tune_o       (tune_o),
        .tune_valid_o (tune_valid_o)
    );

    function automatic logic [15:0] f_inc(input bit fam);
        return fam ? 16'd49152 : 16'd29184;
    endfunction

    function automatic longint f_base(input bit fam);
        return fam ? 64'h81062 : 64'h6CF42;
    endfunction

    function automatic logic [19:0] f_clamp(input longint v);
        if (v < 0) return 20'd0;
        if (v > 64'hFFFFF) return 20'hFFFFF;
        return v[19:0];
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_init(input bit fam);
        m_skip = 1'b1; m_fam = fam; m_integ = 0; m_last = 0;
    endtask

    task automatic do_init(input bit fam);
        @(negedge clk);
        init_i = 1'b1; fam_sel_i = fam;
        model_init(fam);
        @(negedge clk);
        init_i = 1'b0;
        check("R9 init no pulse", tune_valid_o, 0);
    endtask

    task automatic do_strobe(input logic [15:0] s, input string req);
        bit          ev;
        logic [15:0] miss;
        longint      err, res;
        ev = 1'b0;
        @(negedge clk);
        strobe_i = 1'b1; stamp_i = s;
        if (m_skip) begin
            m_skip = 1'b0;
        end else begin
            miss = s - (m_prev + f_inc(m_fam));
            err  = -longint'($signed(miss));
            m_integ = m_integ + err;
            if (m_integ > 64'sd2147483647) m_integ = 64'sd2147483647;
            if (m_integ < -64'sd2147483648) m_integ = -64'sd2147483648;
            res = m_integ * 32;
            if (res != m_last) begin
                ev = 1'b1;
                m_tune = f_clamp(f_base(m_fam) + res);
            end
            m_last = res;
        end
        m_prev = s;
        @(negedge clk);
        strobe_i = 1'b0;
        check(req, tune_valid_o, ev);
        if (ev) check(req, tune_o, m_tune);
    endtask

    function automatic logic [15:0] nxt(input int off);
        return m_prev + f_inc(m_fam) + 16'(off);
    endfunction

    initial begin
        void'($urandom(32'd1234));
        model_init(1'b0);
        m_prev = '0; m_tune = '0;
        repeat (3) @(negedge clk);
        check("R1 reset word", tune_o, 0);
        check("R1 reset valid", tune_valid_o, 0);
        rst_ni = 1'b1;

        // family 0 after reset
        do_strobe(16'd1000, "R2 first sample");
        do_strobe(nxt(0), "R6 zero result unchanged");
        do_strobe(nxt(-10), "R3 R5 family0 word");
        do_strobe(nxt(0), "R6 R10 same result");
        do_strobe(nxt(5), "R4 fast clock negative error");
        @(negedge clk);
        check("R8 pulse one cycle", tune_valid_o, 0);
        check("R8 word held", tune_o, m_tune);

        // family 1 with counter wrap
        do_init(1'b1);
        do_strobe(16'hF000, "R2 first after init");
        do_strobe(nxt(3), "R3 wrap family1");
        do_strobe(nxt(-20000), "R7 clamp high");
        do_strobe(nxt(30000), "R4 large negative");
        do_strobe(nxt(30000), "R7 clamp low");

        // init and strobe together
        @(negedge clk);
        init_i = 1'b1; fam_sel_i = 1'b0; strobe_i = 1'b1; stamp_i = 16'd5;
        model_init(1'b0);
        @(negedge clk);
        init_i = 1'b0; strobe_i = 1'b0;
        check("R9 strobe with init", tune_valid_o, 0);
        do_strobe(16'd100, "R9 R2 skip rearmed");
        do_strobe(nxt(7), "R9 cleared integrator");

        // random phase
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 49) == 0) begin
                do_init(1'($urandom_range(0, 1)));
            end
            if ($urandom_range(0, 3) == 0) begin
                do_strobe(nxt(0), "R6 random steady");
            end else begin
                do_strobe(nxt(int'($urandom_range(0, 600)) - 300), "R3 R4 R5 R7 random");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule